// File: doc/BRIEF.md
# Keyboard and Display Port for an 8-bit Bus

This peripheral puts a keyboard and a character display on the bus of an 8-bit CPU. Three fixed addresses are decoded: a key status register, a key data register and a display output register. Keys arrive one byte at a time on a valid/ready stream. Each key is translated and then held in a single slot until the CPU reads it. While a key waits in the slot, the stream is stalled, so a waiting key is never replaced.

Two incoming codes are not stored as keys. One produces a one-cycle reset strobe toward the CPU and the other a one-cycle break strobe. On the output side, a CPU write to the display register becomes one or more characters on a valid/ready output stream. Characters are remapped on the way out, and one code expands into a three-character erase sequence. The write is acknowledged only once the display stream has taken every character it produced.

Top module: `kbd_disp_port`

## Requirements
- R1: A read of the status address (0xD011) returns 0x80 while a key is waiting and 0x00 when none is.
- R2: A read of the data address (0xD010) while a key waits returns that key with bit 7 set. The same access empties the slot, so a status read that follows returns 0x00.
- R3: A read of the data address with an empty slot returns 0x00, and so does a read of any other address. A write to any address other than the display address is acknowledged at once and sends nothing to the display stream.
- R4: Each incoming key is translated before it is stored. Codes 0x61 to 0x7A lose bit 5 (0x61 becomes 0x41). 0x0A becomes 0x0D. Both 0x7F and 0x08 become 0x5F. All other codes are stored unchanged.
- R5: While a key waits, `key_ready` is low, no new byte is taken, and the stored key keeps its value.
- R6: An accepted 0x12 raises `cpu_reset_req` for exactly one cycle, in the cycle after the handshake. An accepted 0x02 does the same on `cpu_break_req`. Neither code fills the slot.
- R7: A display write keeps only bits 6:0 of the written byte. Code 0x7F is sent as 0x40, code 0x0D is sent as 0x0A, and every other code is sent unchanged.
- R8: A display write whose low 7 bits are 0x5F sends the three characters 0x08, 0x20, 0x08, in that order, and no glyph.
- R9: `bus_ack` for a display write stays low until the last character of that write has been taken. It rises for one cycle, in the cycle after that handshake. While `dsp_ready` is low, `dsp_valid` and `dsp_data` hold steady.
- R10: A synchronous active-high reset empties the key slot, clears the stored key and leaves the display stream idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access to this port's range |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| bus_ack | output | 1 | Access completes at the next clock edge |
| key_valid | input | 1 | Incoming key byte valid |
| key_data | input | 8 | Incoming key byte |
| key_ready | output | 1 | Port can take a key byte |
| dsp_valid | output | 1 | Display character valid |
| dsp_data | output | 7 | Display character |
| dsp_ready | input | 1 | Display sink takes the character |
| cpu_reset_req | output | 1 | One-cycle reset request to the CPU |
| cpu_break_req | output | 1 | One-cycle break request to the CPU |

## Verification
Several properties are checked on every cycle. A waiting key stays fixed until a data read takes it. A data read always empties the slot. The control strobes never coincide and never leave a key behind. A stalled display character holds steady, and a display write is never acknowledged while its characters are still being sent.

Other behaviour can only be shown by the bench's scenarios, which compare values with a scoreboard. This covers the translation tables on both sides and the order of the erase sequence. It also covers the exact return values of the three registers, the single-cycle width of the strobes, and what reset does to a waiting key.

// File: rtl/kdp_pkg.sv
package kdp_pkg;
   typedef enum logic [1:0] {
      DSP_IDLE = 2'd0,
      DSP_SEND = 2'd1,
      DSP_DONE = 2'd2
   } dsp_state_e;

   localparam logic [7:0] KEY_LF     = 8'h0A;
   localparam logic [7:0] KEY_CR     = 8'h0D;
   localparam logic [7:0] KEY_DEL    = 8'h7F;
   localparam logic [7:0] KEY_BS     = 8'h08;
   localparam logic [7:0] KEY_RUBOUT = 8'h5F;
   localparam logic [7:0] KEY_LC_LO  = 8'h61;
   localparam logic [7:0] KEY_LC_HI  = 8'h7A;
   localparam logic [7:0] KEY_RESET  = 8'h12;
   localparam logic [7:0] KEY_BREAK  = 8'h02;

   localparam logic [7:0] OUT_AT     = 8'h40;
   localparam logic [7:0] OUT_SPACE  = 8'h20;
endpackage

// File: rtl/kdp_key_holder.sv
module kdp_key_holder
   import kdp_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int CHAR_W    = 7,
   parameter bit UPCASE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              key_valid,
   input  logic [DATA_W-1:0] key_data,
   output logic              key_ready,
   input  logic              rd_clr,
   output logic              pending,
   output logic [CHAR_W-1:0] held_key,
   output logic              rst_req,
   output logic              brk_req
);
   localparam int CASE_BIT = 5;

   logic              accept;
   logic              is_rst;
   logic              is_brk;
   logic [DATA_W-1:0] remapped;
   logic [DATA_W-1:0] folded;

   assign key_ready = !pending;
   assign accept    = key_valid && !pending;
   assign is_rst    = (key_data == DATA_W'(KEY_RESET));
   assign is_brk    = (key_data == DATA_W'(KEY_BREAK));

   always_comb begin
      remapped = key_data;
      if (key_data == DATA_W'(KEY_LF))
         remapped = DATA_W'(KEY_CR);
      else if ((key_data == DATA_W'(KEY_DEL)) || (key_data == DATA_W'(KEY_BS)))
         remapped = DATA_W'(KEY_RUBOUT);
   end

   generate
      if (UPCASE_EN) begin : g_fold
         always_comb begin
            folded = remapped;
            if ((remapped >= DATA_W'(KEY_LC_LO)) && (remapped <= DATA_W'(KEY_LC_HI)))
               folded[CASE_BIT] = 1'b0;
         end
      end else begin : g_nofold
         assign folded = remapped;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pending  <= 1'b0;
         held_key <= '0;
         rst_req  <= 1'b0;
         brk_req  <= 1'b0;
      end else begin
         rst_req <= accept && is_rst;
         brk_req <= accept && is_brk;
         if (accept && !is_rst && !is_brk) begin
            pending  <= 1'b1;
            held_key <= CHAR_W'(folded);
         end else if (rd_clr) begin
            pending <= 1'b0;
         end
      end
   end

   AST_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (pending && !rd_clr) |=> (pending && $stable(held_key))); // R5
   AST_CTRL_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
      (rst_req || brk_req) |-> !pending); // R6
   AST_CTRL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rst_req, brk_req})); // R6
endmodule

// File: rtl/kdp_disp_seq.sv
module kdp_disp_seq
   import kdp_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CHAR_W   = 7,
   parameter bit ERASE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [DATA_W-1:0] wr_byte,
   output logic              dsp_valid,
   output logic [CHAR_W-1:0] dsp_data,
   input  logic              dsp_ready,
   output logic              done
);
   localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << CHAR_W) - 1);
   localparam int                IDX_W    = 2;
   localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(2);

   dsp_state_e        state;
   logic [CHAR_W-1:0] code;
   logic [CHAR_W-1:0] mapped;
   logic [CHAR_W-1:0] char_q;
   logic              erase_code;
   logic              erase_q;
   logic [IDX_W-1:0]  idx;
   logic              last;

   assign code = CHAR_W'(wr_byte & LOW_MASK);

   always_comb begin
      mapped = code;
      if (code == CHAR_W'(KEY_DEL))
         mapped = CHAR_W'(OUT_AT);
      else if (code == CHAR_W'(KEY_CR))
         mapped = CHAR_W'(KEY_LF);
   end

   generate
      if (ERASE_EN) begin : g_erase
         assign erase_code = (code == CHAR_W'(KEY_RUBOUT));
      end else begin : g_plain
         assign erase_code = 1'b0;
      end
   endgenerate

   assign dsp_valid = (state == DSP_SEND);
   assign done      = (state == DSP_DONE);
   assign last      = !erase_q || (idx == IDX_LAST);

   always_comb begin
      if (erase_q)
         dsp_data = (idx == IDX_W'(1)) ? CHAR_W'(OUT_SPACE) : CHAR_W'(KEY_BS);
      else
         dsp_data = char_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= DSP_IDLE;
         char_q  <= '0;
         erase_q <= 1'b0;
         idx     <= '0;
      end else begin
         unique case (state)
            DSP_IDLE: if (start) begin
               char_q  <= mapped;
               erase_q <= erase_code;
               idx     <= '0;
               state   <= DSP_SEND;
            end
            DSP_SEND: if (dsp_ready) begin
               if (last) state <= DSP_DONE;
               else      idx   <= idx + IDX_W'(1);
            end
            default: state <= DSP_IDLE;
         endcase
      end
   end

   AST_DSP_HOLD: assert property (@(posedge clk) disable iff (rst)
      (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_data))); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R9
endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port
   import kdp_pkg::*;
#(
   parameter int              ADDR_W        = 16,
   parameter int              DATA_W        = 8,
   parameter int              CHAR_W        = 7,
   parameter logic [ADDR_W-1:0] KEY_DATA_ADDR = 16'hD010,
   parameter logic [ADDR_W-1:0] KEY_STAT_ADDR = 16'hD011,
   parameter logic [ADDR_W-1:0] DISP_ADDR     = 16'hD012,
   parameter bit              UPCASE_EN     = 1'b1,
   parameter bit              ERASE_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ack,
   input  logic              key_valid,
   input  logic [DATA_W-1:0] key_data,
   output logic              key_ready,
   output logic              dsp_valid,
   output logic [CHAR_W-1:0] dsp_data,
   input  logic              dsp_ready,
   output logic              cpu_reset_req,
   output logic              cpu_break_req
);
   localparam int FILL_W = DATA_W - 1 - CHAR_W;

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("kbd_disp_port: DATA_W must be 8");
      end
      if (CHAR_W != DATA_W - 1) begin : g_bad_char_w
         $error("kbd_disp_port: CHAR_W must be DATA_W-1");
      end
      if ((KEY_DATA_ADDR == KEY_STAT_ADDR) || (KEY_DATA_ADDR == DISP_ADDR) ||
          (KEY_STAT_ADDR == DISP_ADDR)) begin : g_bad_map
         $error("kbd_disp_port: register addresses must differ");
      end
   endgenerate

   logic              hit_data_rd;
   logic              hit_stat_rd;
   logic              hit_disp_wr;
   logic              rd_clr;
   logic              key_pending;
   logic [CHAR_W-1:0] held_key;
   logic              disp_done;

   assign hit_data_rd = bus_sel && !bus_we && (bus_addr == KEY_DATA_ADDR);
   assign hit_stat_rd = bus_sel && !bus_we && (bus_addr == KEY_STAT_ADDR);
   assign hit_disp_wr = bus_sel &&  bus_we && (bus_addr == DISP_ADDR);
   assign rd_clr      = hit_data_rd && key_pending;

   always_comb begin
      bus_rdata = '0;
      if (hit_stat_rd)
         bus_rdata = {key_pending, {(DATA_W-1){1'b0}}};
      else if (rd_clr)
         bus_rdata = DATA_W'({1'b1, {FILL_W{1'b0}}, held_key});
   end

   assign bus_ack = bus_sel && (!hit_disp_wr || disp_done);

   kdp_key_holder #(
      .DATA_W   (DATA_W),
      .CHAR_W   (CHAR_W),
      .UPCASE_EN(UPCASE_EN)
   ) u_keys (
      .clk      (clk),
      .rst      (rst),
      .key_valid(key_valid),
      .key_data (key_data),
      .key_ready(key_ready),
      .rd_clr   (rd_clr),
      .pending  (key_pending),
      .held_key (held_key),
      .rst_req  (cpu_reset_req),
      .brk_req  (cpu_break_req)
   );

   kdp_disp_seq #(
      .DATA_W  (DATA_W),
      .CHAR_W  (CHAR_W),
      .ERASE_EN(ERASE_EN)
   ) u_disp (
      .clk      (clk),
      .rst      (rst),
      .start    (hit_disp_wr),
      .wr_byte  (bus_wdata),
      .dsp_valid(dsp_valid),
      .dsp_data (dsp_data),
      .dsp_ready(dsp_ready),
      .done     (disp_done)
   );

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (hit_data_rd && key_pending) |=> !key_pending); // R2
   AST_ACK_WAIT: assert property (@(posedge clk) disable iff (rst)
      (hit_disp_wr && dsp_valid) |-> !bus_ack); // R9
   AST_NO_TAKE_PENDING: assert property (@(posedge clk) disable iff (rst)
      key_pending |-> !key_ready); // R5
endmodule

// File: tb/kbd_disp_port_test.sv
module kbd_disp_port_test;
   localparam logic [15:0] A_DATA = 16'hD010;
   localparam logic [15:0] A_STAT = 16'hD011;
   localparam logic [15:0] A_DISP = 16'hD012;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bus_sel = 1'b0;
   logic       bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bus_ack;
   logic       key_valid = 1'b0;
   logic [7:0] key_data = '0;
   logic       key_ready;
   logic       dsp_valid;
   logic [6:0] dsp_data;
   logic       dsp_ready;
   logic       cpu_reset_req;
   logic       cpu_break_req;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int stall_mode = 0;
   logic [6:0] exp_q[$];

   always #4 clk = ~clk;

   kbd_disp_port uut (
      .clk(clk), .rst(rst),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
      .key_valid(key_valid), .key_data(key_data), .key_ready(key_ready),
      .dsp_valid(dsp_valid), .dsp_data(dsp_data), .dsp_ready(dsp_ready),
      .cpu_reset_req(cpu_reset_req), .cpu_break_req(cpu_break_req)
   );

   always @(negedge clk) begin
      cyc <= cyc + 1;
      case (stall_mode)
         0: dsp_ready <= 1'b1;
         1: dsp_ready <= (cyc % 3) == 2;
         default: dsp_ready <= 1'b0;
      endcase
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compare each accepted display character
   initial begin
      forever begin
         @(negedge clk); #1;
         if (!rst && dsp_valid && dsp_ready) begin
            if (exp_q.size() == 0)
               check(1'b0, "R7 unexpected display char", int'(dsp_data), -1);
            else begin
               logic [6:0] e;
               e = exp_q.pop_front();
               check(dsp_data == e, "R7/R8 display char", int'(dsp_data), int'(e));
            end
         end
      end
   end

   function automatic logic [7:0] key_model(input logic [7:0] d);
      if (d == 8'h0A) return 8'h0D;
      if (d == 8'h7F || d == 8'h08) return 8'h5F;
      if (d >= 8'h61 && d <= 8'h7A) return d - 8'h20;
      return d;
   endfunction

   task automatic push_disp(input logic [7:0] d);
      logic [6:0] c;
      c = d[6:0];
      if (c == 7'h5F) begin
         exp_q.push_back(7'h08); exp_q.push_back(7'h20); exp_q.push_back(7'h08);
      end else if (c == 7'h7F) exp_q.push_back(7'h40);
      else if (c == 7'h0D) exp_q.push_back(7'h0A);
      else exp_q.push_back(c);
   endtask

   task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic disp_write(input logic [7:0] d);
      int n;
      push_disp(d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_DISP; bus_wdata = d;
      n = 0;
      forever begin
         @(negedge clk); #1;
         n++;
         if (bus_ack || n > 200) break;
      end
      check(bus_ack, "R9 ack arrives", int'(bus_ack), 1);
      check(exp_q.size() == 0, "R9 all chars taken at ack", exp_q.size(), 0);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic send_key(input logic [7:0] d);
      @(negedge clk);
      key_valid = 1'b1; key_data = d;
      #1;
      while (!key_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      key_valid = 1'b0;
   endtask

   task automatic expect_key(input logic [7:0] exp, input string tag);
      logic [7:0] r;
      cpu_read(A_STAT, r);
      check(r == 8'h80, "R1 status with key", int'(r), 8'h80);
      cpu_read(A_DATA, r);
      check(r == (exp | 8'h80), tag, int'(r), int'(exp | 8'h80));
      cpu_read(A_STAT, r);
      check(r == 8'h00, "R2 status after data read", int'(r), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      logic [7:0] r;
      logic [7:0] probes[6] = '{8'h61, 8'h7A, 8'h0A, 8'h7F, 8'h08, 8'h60};
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R10 reset state
      check(key_ready == 1'b1, "R10 key_ready after reset", int'(key_ready), 1);
      check(dsp_valid == 1'b0, "R10 display idle after reset", int'(dsp_valid), 0);
      cpu_read(A_STAT, r);
      check(r == 8'h00, "R1 status empty", int'(r), 0);
      cpu_read(A_DATA, r);
      check(r == 8'h00, "R3 data read when empty", int'(r), 0);

      // R4 translation
      send_key(8'h41);
      expect_key(8'h41, "R2 plain key read");
      foreach (probes[i]) begin
         send_key(probes[i]);
         expect_key(key_model(probes[i]), "R4 translated key");
      end
      send_key(8'h7B);
      expect_key(8'h7B, "R4 code above lowercase range unchanged");

      // R5 pending not overwritten
      send_key(8'h62);
      @(negedge clk);
      key_valid = 1'b1; key_data = 8'h33;
      for (int k = 0; k < 5; k++) begin
         #1 check(key_ready == 1'b0, "R5 key_ready low while pending", int'(key_ready), 0);
         @(negedge clk);
      end
      key_valid = 1'b0;
      expect_key(8'h42, "R5 held key kept");

      // R3 other addresses
      send_key(8'h31);
      cpu_read(16'hD013, r);
      check(r == 8'h00, "R3 other address read", int'(r), 0);
      cpu_read(16'hD012, r);
      check(r == 8'h00, "R3 display address read", int'(r), 0);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 8'h55;
      #1 check(bus_ack == 1'b1, "R3 foreign write acked", int'(bus_ack), 1);
      @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
      repeat (3) begin
         @(negedge clk); #1;
         check(dsp_valid == 1'b0, "R3 foreign write sends nothing", int'(dsp_valid), 0);
      end
      expect_key(8'h31, "R3 key survives foreign accesses");

      // R6 control strobes
      send_key(8'h12);
      #1 check(cpu_reset_req == 1'b1, "R6 reset strobe", int'(cpu_reset_req), 1);
      check(cpu_break_req == 1'b0, "R6 no break on reset", int'(cpu_break_req), 0);
      @(negedge clk); #1;
      check(cpu_reset_req == 1'b0, "R6 reset strobe one cycle", int'(cpu_reset_req), 0);
      send_key(8'h02);
      #1 check(cpu_break_req == 1'b1, "R6 break strobe", int'(cpu_break_req), 1);
      @(negedge clk); #1;
      check(cpu_break_req == 1'b0, "R6 break strobe one cycle", int'(cpu_break_req), 0);
      cpu_read(A_STAT, r);
      check(r == 8'h00, "R6 control codes not stored", int'(r), 0);

      // R7 R8 R9 display with several ready patterns
      for (int m = 0; m < 3; m++) begin
         stall_mode = (m == 2) ? 1 : m;
         disp_write(8'hC1);
         disp_write(8'hFF);
         disp_write(8'h8D);
         disp_write(8'h5F);
         disp_write(8'h0D);
         disp_write(8'hDF);
         disp_write(8'h7E);
      end
      stall_mode = 2;
      @(negedge clk);
      push_disp(8'h5F);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_DISP; bus_wdata = 8'h5F;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk); #1;
         check(bus_ack == 1'b0, "R9 ack held while stalled", int'(bus_ack), 0);
         check(dsp_data == 7'h08, "R9 stalled data steady", int'(dsp_data), 8'h08);
      end
      stall_mode = 0;
      forever begin @(negedge clk); #1; if (bus_ack) break; end
      check(exp_q.size() == 0, "R8 erase sequence done", exp_q.size(), 0);
      bus_sel = 1'b0; bus_we = 1'b0;

      // R10 reset clears a waiting key
      send_key(8'h39);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      #1 check(key_ready == 1'b1, "R10 slot empty after reset", int'(key_ready), 1);
      cpu_read(A_STAT, r);
      check(r == 8'h00, "R10 status after reset", int'(r), 0);
      cpu_read(A_DATA, r);
      check(r == 8'h00, "R10 data after reset", int'(r), 0);

      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule